// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces data-memory addresses for a signal-processing datapath. It keeps a small file of address pointers. Each pointer has its own base and length registers. On every access request the block presents the selected pointer as the address. At the same clock edge it writes back that pointer after a post-modify step. The access itself chooses how the step is applied: plain two's-complement addition, wraparound inside a circular window, or reverse-carry addition for FFT butterflies.

Circular mode suits filter sample histories. The pointer marks the oldest sample, the new sample is stored there, and the pointer then moves on to the next-oldest slot without ever leaving the window. Reverse-carry mode walks a power-of-two table in bit-reversed order. A separate write port loads the pointer, base and length registers.

Top module: `dspAguTop`

## Requirements
- R1: After reset every pointer, base and length register is zero, so every pointer reads back as address 0.
- R2: `addrOut` shows the current value of the pointer selected by `reqIdx`, before any update. A post-modify result is written at the next rising clock edge and is first seen on the following request.
- R3: Mode code 2'b00 (linear) writes back pointer + step, treating the step as a signed 32-bit value and dropping any carry out of 32 bits.
- R4: Mode code 2'b01 (circular) takes off = pointer - base and s = off + step. If s is at least the length L, it writes back base + s - L. If s is negative, it writes back base + s + L. Otherwise it writes back base + s. The pointer is assumed to lie in the window and |step| <= L.
- R5: Mode code 2'b10 (reverse-carry) treats the length as N, a power of two. It adds the step to the low log2(N) pointer bits with the carry running from the most significant of those bits toward bit 0, and drops the final carry. Pointer bits at and above bit log2(N) are kept.
- R6: Mode code 2'b11, or `reqValid` low, leaves every pointer unchanged.
- R7: When `cfgWe` is high, `cfgSel` 2'b00, 2'b01 or 2'b10 writes `cfgData` at the clock edge into the pointer, base or length of register `cfgIdx`. `cfgSel` 2'b11 writes nothing.
- R8: If a pointer write and a step request target the same register in the same cycle, the written value wins.
- R9: A step request changes only the pointer of the register it selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cfgWe | input | 1 | Register write enable |
| cfgSel | input | 2 | Write target: 0 pointer, 1 base, 2 length, 3 none |
| cfgIdx | input | IDX_W (2) | Register written |
| cfgData | input | ADDR_W (32) | Write value |
| reqValid | input | 1 | Access request |
| reqIdx | input | IDX_W (2) | Pointer used by the access |
| reqMode | input | 2 | Update mode: 0 linear, 1 circular, 2 reverse-carry, 3 hold |
| reqStep | input | ADDR_W (32) | Signed post-modify step |
| addrOut | output | ADDR_W (32) | Address for this access (pre-update pointer) |

## Verification
The address is a combinational read of the pointer file, so it is due in the same cycle as the request. Any pointer change from a step or a register write becomes visible one rising edge later. The bench drives inputs at the falling edge and samples `addrOut` 1 ns afterwards, before the next rising edge. Each step's result is therefore checked as the address of the next request to the same register. Effects that the ports cannot show directly, such as hold, ignored writes, write priority and isolation between registers, are read back with hold-mode requests in the cycles that follow.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_LIN  = 2'b00,
    MODE_CIRC = 2'b01,
    MODE_BREV = 2'b10,
    MODE_HOLD = 2'b11
  } aguMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     cfgPtr;
    logic     cfgBase;
    logic     cfgLen;
    logic     stepEn;
    aguMode_e mode;
  } aguStrobes_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [1:0]       reqMode,
  output aguStrobes_t      strb
);

  aguMode_e modeIn;
  logic     ptrClash;

  always_comb begin
    modeIn       = aguMode_e'(reqMode);
    strb.cfgPtr  = cfgWe && (cfgSel == 2'b00);
    strb.cfgBase = cfgWe && (cfgSel == 2'b01);
    strb.cfgLen  = cfgWe && (cfgSel == 2'b10);
    ptrClash     = strb.cfgPtr && (cfgIdx == reqIdx);
    strb.stepEn  = reqValid && (modeIn != MODE_HOLD) && !ptrClash;
    strb.mode    = modeIn;
  end

  // R7
  cfg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cfgPtr, strb.cfgBase, strb.cfgLen}));

  // R7
  cfg_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel == 2'b11) |-> !(strb.cfgPtr || strb.cfgBase || strb.cfgLen));

  // R6
  hold_no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqMode == 2'b11) |-> !strb.stepEn);

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobes_t       strb,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [ADDR_W-1:0] reqStep,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int EXT_W = ADDR_W + 2;

  logic [NUM_REGS-1:0][ADDR_W-1:0] ptrQ;
  logic [NUM_REGS-1:0][ADDR_W-1:0] baseQ;
  logic [NUM_REGS-1:0][ADDR_W-1:0] lenQ;

  logic [ADDR_W-1:0] curPtr, curBase, curLen, brMask;
  logic [ADDR_W-1:0] circNext, brevNext, nextPtr;
  logic signed [EXT_W-1:0] offS, stepS, lenS, sumS, wrapS;
  logic brCarry;

  assign curPtr  = ptrQ[reqIdx];
  assign curBase = baseQ[reqIdx];
  assign curLen  = lenQ[reqIdx];
  assign addrOut = curPtr;
  assign brMask  = curLen - 1'b1;

  // circular window update
  always_comb begin
    offS  = $signed({2'b00, curPtr - curBase});
    stepS = $signed({{2{reqStep[ADDR_W-1]}}, reqStep});
    lenS  = $signed({2'b00, curLen});
    sumS  = offS + stepS;
    if (sumS >= lenS)      wrapS = sumS - lenS;
    else if (sumS < 0)     wrapS = sumS + lenS;
    else                   wrapS = sumS;
    circNext = curBase + wrapS[ADDR_W-1:0];
  end

  // reverse-carry update: carry runs from high masked bit toward bit 0
  always_comb begin
    brevNext = curPtr;
    brCarry  = 1'b0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      if (brMask[i]) begin
        brevNext[i] = curPtr[i] ^ reqStep[i] ^ brCarry;
        brCarry     = (curPtr[i] & reqStep[i]) | (brCarry & (curPtr[i] ^ reqStep[i]));
      end
    end
  end

  always_comb begin
    case (strb.mode)
      MODE_LIN:  nextPtr = curPtr + reqStep;
      MODE_CIRC: nextPtr = circNext;
      MODE_BREV: nextPtr = brevNext;
      default:   nextPtr = curPtr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      baseQ <= '0;
      lenQ  <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strb.cfgPtr && cfgIdx == IDX_W'(r))
          ptrQ[r] <= cfgData;
        else if (strb.stepEn && reqIdx == IDX_W'(r))
          ptrQ[r] <= nextPtr;
        if (strb.cfgBase && cfgIdx == IDX_W'(r)) baseQ[r] <= cfgData;
        if (strb.cfgLen  && cfgIdx == IDX_W'(r)) lenQ[r]  <= cfgData;
      end
    end
  end

  // R4
  circ_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && strb.mode == MODE_CIRC && !strb.cfgBase && !strb.cfgLen
     && (curPtr - curBase) < curLen)
    |=> (ptrQ[$past(reqIdx)] - baseQ[$past(reqIdx)]) < lenQ[$past(reqIdx)]);

  // R5
  brev_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && strb.mode == MODE_BREV && !strb.cfgLen)
    |=> (ptrQ[$past(reqIdx)] & ~(lenQ[$past(reqIdx)] - 1'b1))
        == ($past(curPtr) & ~($past(curLen) - 1'b1)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepEn && !strb.cfgPtr) |=> $stable(ptrQ));

  // R8
  cfg_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgPtr |=> ptrQ[$past(cfgIdx)] == $past(cfgData));

endmodule

// File: rtl/dspAguTop.sv
module dspAguTop
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [1:0]        reqMode,
  input  logic [ADDR_W-1:0] reqStep,
  output logic [ADDR_W-1:0] addrOut
);

  aguStrobes_t strb;

  agu_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .reqValid(reqValid), .reqIdx(reqIdx), .reqMode(reqMode),
    .strb(strb)
  );

  agu_datapath #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgIdx(cfgIdx), .cfgData(cfgData),
    .reqIdx(reqIdx), .reqStep(reqStep),
    .addrOut(addrOut)
  );

endmodule

// File: tb/test_dspAguTop.sv
`timescale 1ns/1ps
module test_dspAguTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqIdx = '0;
  logic [1:0]  reqMode = '0;
  logic [31:0] reqStep = '0;
  logic [31:0] addrOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dspAguTop i_dspAguTop (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .reqValid(reqValid), .reqIdx(reqIdx), .reqMode(reqMode),
    .reqStep(reqStep), .addrOut(addrOut)
  );

  // {idx, mode, step, expected address}
  localparam int NV = 28;
  localparam logic [67:0] VEC [NV] = '{
    {2'd0, 2'd1, 32'd3,          32'd100},   // R4
    {2'd0, 2'd1, 32'd3,          32'd103},
    {2'd0, 2'd1, 32'd3,          32'd106},
    {2'd0, 2'd1, -32'sd2,        32'd101},   // R4 wrap up
    {2'd0, 2'd1, 32'd8,          32'd107},   // R4 wrap down
    {2'd0, 2'd1, -32'sd8,        32'd107},   // R4 step = K
    {2'd0, 2'd3, 32'd5,          32'd107},   // R6
    {2'd0, 2'd0, 32'd0,          32'd107},   // R6
    {2'd1, 2'd0, 32'd8,          32'd1000},  // R3
    {2'd1, 2'd0, -32'sd4,        32'd1008},
    {2'd1, 2'd3, 32'd5,          32'd1004},  // R6
    {2'd1, 2'd0, 32'd0,          32'd1004},
    {2'd2, 2'd2, 32'd4,          32'd0},     // R5
    {2'd2, 2'd2, 32'd4,          32'd4},
    {2'd2, 2'd2, 32'd4,          32'd2},
    {2'd2, 2'd2, 32'd4,          32'd6},
    {2'd2, 2'd2, 32'd4,          32'd1},
    {2'd2, 2'd2, 32'd4,          32'd5},
    {2'd2, 2'd2, 32'd4,          32'd3},
    {2'd2, 2'd2, 32'd4,          32'd7},
    {2'd2, 2'd3, 32'd0,          32'd0},     // R5 carry out dropped
    {2'd3, 2'd2, 32'd2,          32'h40},    // R5 upper bits kept
    {2'd3, 2'd2, 32'd2,          32'h42},
    {2'd3, 2'd2, 32'd2,          32'h41},
    {2'd3, 2'd2, 32'd2,          32'h43},
    {2'd3, 2'd3, 32'd0,          32'h40},
    {2'd1, 2'd0, 32'hFFFFFC18,   32'd1004},  // R3 negative
    {2'd1, 2'd3, 32'd0,          32'd4}
  };

  task automatic check(input logic [31:0] exp, input string req);
    checks++;
    if (addrOut !== exp) begin
      errors++;
      $display("FAIL %s addrOut=%0h expected=%0h", req, addrOut, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] idx, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic access(input logic [1:0] idx, input logic [1:0] mode,
                        input logic [31:0] step, input logic [31:0] exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqIdx = idx; reqMode = mode; reqStep = step;
    #1 check(exp, req);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: all pointers read zero after reset
    for (int r = 0; r < 4; r++) access(2'(r), 2'd3, 32'd0, 32'd0, "R1");

    // R7 configuration of all registers
    cfgWrite(0, 2'd1, 32'd100); cfgWrite(0, 2'd2, 32'd8); cfgWrite(0, 2'd0, 32'd100);
    cfgWrite(1, 2'd0, 32'd1000);
    cfgWrite(2, 2'd2, 32'd8);
    cfgWrite(3, 2'd2, 32'd4);   cfgWrite(3, 2'd0, 32'h40);

    // R2: vector walk, each address is the pre-update pointer
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      reqValid = 1'b1;
      reqIdx   = VEC[v][67:66];
      reqMode  = VEC[v][65:64];
      reqStep  = VEC[v][63:32];
      #1 check(VEC[v][31:0], "R2 vector");
    end
    @(negedge clk);
    reqValid = 1'b0;

    // R8: pointer write beats same-cycle step on the same register
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'd0; cfgIdx = 2'd1; cfgData = 32'd2000;
    reqValid = 1'b1; reqIdx = 2'd1; reqMode = 2'd0; reqStep = 32'd8;
    #1 check(32'd4, "R8 pre");
    @(negedge clk);
    cfgWe = 1'b0; reqValid = 1'b0;
    access(1, 2'd3, 32'd0, 32'd2000, "R8");

    // R9: step on r1 leaves others untouched
    access(1, 2'd0, 32'd1, 32'd2000, "R9 step");
    access(0, 2'd3, 32'd0, 32'd107,  "R9 r0");
    access(2, 2'd3, 32'd0, 32'd0,    "R9 r2");
    access(3, 2'd3, 32'd0, 32'h40,   "R9 r3");
    access(1, 2'd3, 32'd0, 32'd2001, "R9 r1");

    // R7: select 3 writes nothing
    cfgWrite(1, 2'd3, 32'd5555);
    access(1, 2'd3, 32'd0, 32'd2001, "R7 ignored");

    // R6: reqValid low with a step pending
    @(negedge clk);
    reqValid = 1'b0; reqIdx = 2'd1; reqMode = 2'd0; reqStep = 32'd9;
    access(1, 2'd3, 32'd0, 32'd2001, "R6 invalid");

    // R7 / R4: new window base 200 length 4 at top entry, +1 wraps to base
    cfgWrite(0, 2'd1, 32'd200); cfgWrite(0, 2'd2, 32'd4); cfgWrite(0, 2'd0, 32'd203);
    access(0, 2'd1, 32'd1, 32'd203, "R7 load");
    access(0, 2'd3, 32'd0, 32'd200, "R4 wrap");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule